// File: doc/BRIEF.md
# Synchronous Pipelined Burst SRAM Front End

This block is a small synchronous SRAM with four byte lanes and a pipelined read path. Every control input is sampled on the rising clock edge. Two address strobes compete to load a new external address. One comes from a processor-side master and one from a controller-side master. A load also examines three chip enables and either selects or deselects the memory. Once an address is loaded, an advance input steps the two low address bits through a linear burst of four that wraps around. The upper bits stay fixed.

On each edge the block works out one access address. Any write enabled on that edge goes to that address, either a global write or a per-lane byte write. The same edge captures the previous content of that location into a read register, which is presented during the following cycle. Read data leaves on a dedicated output bus with a valid flag rather than on bidirectional pins. The output enable gates that bus combinationally. The bus is forced quiet while the memory is deselected. It is also quiet for the first cycle after a deselected memory is selected again.

Top module: `sburst_sram`

## Requirements
- R1: While reset is active, and right after it, the memory is deselected, `rvalid` is 0 and `rdata` is 0.
- R2: A load happens when a strobe is honoured with `cs1_n`=0, `cs2`=1 and `cs3_n`=0. It captures `addr` as the access address for that edge. The content of that address appears on `rdata` during the next cycle, which is one cycle of latency.
- R3: The processor strobe `strb_p_n` has no effect while `cs1_n` is 1. In that case a burst in progress behaves as if no strobe were low. When both strobes are low with `cs1_n`=0, exactly one load of `addr` takes place.
- R4: When a load and a low `adv_n` fall on the same edge, the load wins and the loaded address is accessed.
- R5: The chip enables are examined only on load edges. Changing them on other edges does not alter selection or output.
- R6: On an edge with no load, `adv_n`=0 while selected increments address bits [1:0] modulo 4 (3 wraps to 0) and leaves the upper bits unchanged. With `adv_n`=1 the same address is accessed again.
- R7: `gw_n`=0 on a selected edge writes all four lanes from `wdata`, whatever `bwe_n` and `bsel_n` are. Lane i is `wdata[8i+7:8i]`.
- R8: With `gw_n`=1 and `bwe_n`=0, only the lanes i with `bsel_n[i]`=0 are written. With both `gw_n` and `bwe_n` at 1, nothing is written.
- R9: The read register captures the content of the access address as it was before that same edge's write.
- R10: `rvalid` follows `oe_n` combinationally. Data is flagged valid only while `oe_n`=0, and `rdata` is 0 whenever `rvalid` is 0.
- R11: For the first cycle after a deselected memory is selected by a load, the output stays invalid even with `oe_n`=0.
- R12: A load with the chip enables inactive deselects the memory. Writes are then ignored and no output is driven until a later load selects it again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | AW | External address, AW = log2(DEPTH) |
| cs1_n | input | 1 | Chip enable, active low; also gates the processor strobe |
| cs2 | input | 1 | Chip enable, active high |
| cs3_n | input | 1 | Chip enable, active low |
| strb_p_n | input | 1 | Processor address strobe, active low, higher priority |
| strb_c_n | input | 1 | Controller address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| gw_n | input | 1 | Global write, active low |
| bwe_n | input | 1 | Byte write enable, active low |
| bsel_n | input | 4 | Per-lane byte select, active low |
| wdata | input | 32 | Write data, four 8-bit lanes |
| oe_n | input | 1 | Output enable, active low, combinational |
| rdata | output | 32 | Read data, 0 when not valid |
| rvalid | output | 1 | Read data valid flag |

## Verification
Several pairs of functions can land on the same clock edge, and the bench forces each pair deliberately. A byte write to the address being read tests read capture against same-edge write: the next cycle must show the old word and the cycle after must show the merged one. A strobe load together with a low advance must return the loaded address, not the incremented one. A processor strobe blocked by a high `cs1_n` during a burst advance must leave the burst stepping on as if no strobe were present.

// File: rtl/sbs_pkg.sv
package sbs_pkg;
    localparam int LANES  = 4;
    localparam int LANE_W = 8;
    localparam int DATA_W = LANES * LANE_W;

    typedef enum logic [1:0] {
        K_HOLD  = 2'd0,
        K_ADV   = 2'd1,
        K_LOAD  = 2'd2,
        K_DESEL = 2'd3
    } kind_t;
endpackage

// File: rtl/sbs_ctrl.sv
module sbs_ctrl #(
    parameter int AW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] addr,
    input  logic          cs1_n,
    input  logic          cs2,
    input  logic          cs3_n,
    input  logic          strb_p_n,
    input  logic          strb_c_n,
    input  logic          adv_n,
    output logic [AW-1:0] acc_addr,
    output logic          acc_live,
    output logic          sel_q,
    output logic          mask_q
);
    import sbs_pkg::*;

    typedef struct packed {
        logic [AW-1:0] addr;
        logic          sel;
        logic          mask;
    } st_t;

    st_t   st_d, st_q;
    kind_t kind;
    logic  p_take, load, en_ok;

    always_comb begin
        p_take = !strb_p_n && !cs1_n;
        load   = p_take || !strb_c_n;
        en_ok  = !cs1_n && cs2 && !cs3_n;
        if (load)
            kind = en_ok ? K_LOAD : K_DESEL;
        else if (!adv_n && st_q.sel)
            kind = K_ADV;
        else
            kind = K_HOLD;

        st_d = st_q;
        case (kind)
            K_LOAD: begin
                st_d.addr = addr;
                st_d.sel  = 1'b1;
            end
            K_DESEL: st_d.sel = 1'b0;
            K_ADV:   st_d.addr = {st_q.addr[AW-1:2], 2'(st_q.addr[1:0] + 2'd1)};
            default: st_d = st_q;
        endcase
        st_d.mask = st_d.sel && !st_q.sel;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign acc_addr = st_d.addr;
    assign acc_live = st_d.sel;
    assign sel_q    = st_q.sel;
    assign mask_q   = st_q.mask;

    AST_LOAD_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        (load && en_ok) |=> (st_q.sel && st_q.addr == $past(addr))); // R2
    AST_P_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (!strb_p_n && cs1_n && strb_c_n && adv_n && st_q.sel) |=> (st_q.sel && $stable(st_q.addr))); // R3
    AST_CE_NOT_SAMPLED: assert property (@(posedge clk) disable iff (!rst_n)
        (!load) |=> (st_q.sel == $past(st_q.sel))); // R5
    AST_ADV_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !adv_n && st_q.sel) |=> (st_q.addr[AW-1:2] == $past(st_q.addr[AW-1:2])
            && st_q.addr[1:0] == 2'($past(st_q.addr[1:0]) + 2'd1))); // R6
    AST_DESELECT: assert property (@(posedge clk) disable iff (!rst_n)
        (load && !en_ok) |=> !st_q.sel); // R12
endmodule

// File: rtl/sbs_wdec.sv
module sbs_wdec (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    live,
    input  logic                    gw_n,
    input  logic                    bwe_n,
    input  logic [sbs_pkg::LANES-1:0] bsel_n,
    output logic [sbs_pkg::LANES-1:0] we
);
    import sbs_pkg::*;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        always_comb we[i] = live && (!gw_n || (!bwe_n && !bsel_n[i]));
    end

    AST_GW_ALL_LANES: assert property (@(posedge clk) disable iff (!rst_n)
        (live && !gw_n) |-> (we == {LANES{1'b1}})); // R7
    AST_NO_WRITE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (gw_n && bwe_n) |-> (we == '0)); // R8
    AST_DESEL_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (!live) |-> (we == '0)); // R12
endmodule

// File: rtl/sbs_lanes.sv
module sbs_lanes #(
    parameter int DEPTH = 16,
    parameter int AW    = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [AW-1:0]             acc_addr,
    input  logic [sbs_pkg::LANES-1:0] we,
    input  logic [sbs_pkg::DATA_W-1:0] wdata,
    output logic [sbs_pkg::DATA_W-1:0] rd_q
);
    import sbs_pkg::*;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        logic [LANE_W-1:0] mem [DEPTH];
        logic [LANE_W-1:0] rd_d;

        always_comb rd_d = mem[acc_addr];

        always_ff @(posedge clk) begin
            if (we[i])
                mem[acc_addr] <= wdata[i*LANE_W +: LANE_W];
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                rd_q[i*LANE_W +: LANE_W] <= '0;
            else
                rd_q[i*LANE_W +: LANE_W] <= rd_d;
        end
    end
endmodule

// File: rtl/sburst_sram.sv
module sburst_sram #(
    parameter int DEPTH = 16,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] addr,
    input  logic          cs1_n,
    input  logic          cs2,
    input  logic          cs3_n,
    input  logic          strb_p_n,
    input  logic          strb_c_n,
    input  logic          adv_n,
    input  logic          gw_n,
    input  logic          bwe_n,
    input  logic [3:0]    bsel_n,
    input  logic [31:0]   wdata,
    input  logic          oe_n,
    output logic [31:0]   rdata,
    output logic          rvalid
);
    import sbs_pkg::*;

    logic [AW-1:0]     acc_addr;
    logic              acc_live, sel_q, mask_q;
    logic [LANES-1:0]  we;
    logic [DATA_W-1:0] rd_q;

    sbs_ctrl #(.AW(AW)) i_ctrl (
        .clk(clk), .rst_n(rst_n), .addr(addr),
        .cs1_n(cs1_n), .cs2(cs2), .cs3_n(cs3_n),
        .strb_p_n(strb_p_n), .strb_c_n(strb_c_n), .adv_n(adv_n),
        .acc_addr(acc_addr), .acc_live(acc_live),
        .sel_q(sel_q), .mask_q(mask_q)
    );

    sbs_wdec i_wdec (
        .clk(clk), .rst_n(rst_n), .live(acc_live),
        .gw_n(gw_n), .bwe_n(bwe_n), .bsel_n(bsel_n), .we(we)
    );

    sbs_lanes #(.DEPTH(DEPTH), .AW(AW)) i_lanes (
        .clk(clk), .rst_n(rst_n), .acc_addr(acc_addr),
        .we(we), .wdata(wdata), .rd_q(rd_q)
    );

    always_comb begin
        rvalid = !oe_n && sel_q && !mask_q;
        rdata  = rvalid ? rd_q : '0;
    end

    AST_FIRST_CYCLE_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sel_q) |-> !rvalid); // R11
    AST_OE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n |-> (!rvalid && rdata == '0)); // R10
    AST_DESEL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_q |-> !rvalid); // R12
endmodule

// File: tb/test_sburst_sram.sv
module test_sburst_sram;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  addr = '0;
    logic        cs1_n = 1'b0, cs2 = 1'b1, cs3_n = 1'b0;
    logic        strb_p_n = 1'b1, strb_c_n = 1'b1, adv_n = 1'b1;
    logic        gw_n = 1'b1, bwe_n = 1'b1, oe_n = 1'b0;
    logic [3:0]  bsel_n = 4'hF;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        rvalid;

    int compared = 0;
    int mismatched = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    sburst_sram #(.DEPTH(16)) i_sburst_sram (
        .clk(clk), .rst_n(rst_n), .addr(addr),
        .cs1_n(cs1_n), .cs2(cs2), .cs3_n(cs3_n),
        .strb_p_n(strb_p_n), .strb_c_n(strb_c_n), .adv_n(adv_n),
        .gw_n(gw_n), .bwe_n(bwe_n), .bsel_n(bsel_n), .wdata(wdata),
        .oe_n(oe_n), .rdata(rdata), .rvalid(rvalid)
    );

    typedef struct packed {
        logic [3:0]  a;
        logic [2:0]  ce;   // {cs1_n, cs2, cs3_n}
        logic        p, c, adv, gw, bwe;
        logic [3:0]  bsel;
        logic [31:0] wd;
        logic        oe;
        logic        ev;
        logic [31:0] ed;
        logic [3:0]  rq;
    } vec_t;

    function automatic vec_t mk(logic [3:0] a, logic [2:0] ce, logic p, logic c, logic adv,
                                logic gw, logic bwe, logic [3:0] bsel, logic [31:0] wd,
                                logic oe, logic ev, logic [31:0] ed, logic [3:0] rq);
        mk = '{a, ce, p, c, adv, gw, bwe, bsel, wd, oe, ev, ed, rq};
    endfunction

    localparam int NV = 18;
    localparam vec_t VEC [NV] = '{
        mk(4'd4, 3'b010, 1, 0, 1, 0, 1, 4'hF, 32'h11223344, 0, 0, 32'h0,        4'd11), // R11 first cycle masked, R7 write 4
        mk(4'd0, 3'b010, 1, 1, 0, 0, 1, 4'hF, 32'h55667788, 1, 0, 32'h0,        4'd10), // R10 oe high, write 5
        mk(4'd0, 3'b010, 1, 1, 0, 0, 1, 4'hF, 32'h99AABBCC, 1, 0, 32'h0,        4'd7),  // R7 write 6
        mk(4'd0, 3'b010, 1, 1, 0, 0, 1, 4'hF, 32'hDDEEFF00, 1, 0, 32'h0,        4'd7),  // R7 write 7
        mk(4'd0, 3'b010, 1, 1, 0, 1, 1, 4'hF, 32'h0,        0, 1, 32'h11223344, 4'd6),  // R6 wrap 7->4
        mk(4'd0, 3'b010, 1, 1, 0, 1, 0, 4'b1010, 32'hA1B2C3D4, 0, 1, 32'h55667788, 4'd9), // R9 old data on byte write
        mk(4'd0, 3'b110, 1, 1, 1, 1, 1, 4'h0, 32'hFFFFFFFF, 0, 1, 32'h55B277D4, 4'd8),  // R8 merged lanes 0,2
        mk(4'd0, 3'b000, 1, 1, 1, 1, 1, 4'hF, 32'h0,        0, 1, 32'h55B277D4, 4'd5),  // R5 enables ignored, R8 no write
        mk(4'd0, 3'b110, 0, 1, 0, 1, 1, 4'hF, 32'h0,        0, 1, 32'h99AABBCC, 4'd3),  // R3 blocked strobe, burst to 6
        mk(4'd7, 3'b010, 0, 0, 1, 1, 1, 4'hF, 32'h0,        0, 1, 32'hDDEEFF00, 4'd3),  // R3 both strobes load 7
        mk(4'd4, 3'b000, 1, 0, 1, 0, 1, 4'hF, 32'h0,        0, 0, 32'h0,        4'd12), // R12 deselect, write dropped
        mk(4'd0, 3'b010, 1, 1, 0, 1, 1, 4'hF, 32'h0,        0, 0, 32'h0,        4'd12), // R12 stays deselected
        mk(4'd4, 3'b010, 1, 0, 1, 1, 1, 4'hF, 32'h0,        0, 0, 32'h0,        4'd11), // R11 reselect masked
        mk(4'd0, 3'b010, 1, 1, 1, 1, 1, 4'hF, 32'h0,        0, 1, 32'h11223344, 4'd12), // R12 addr 4 kept old data
        mk(4'd0, 3'b010, 1, 1, 1, 1, 1, 4'hF, 32'h0,        1, 0, 32'h0,        4'd10), // R10 oe high
        mk(4'd6, 3'b010, 1, 0, 0, 1, 1, 4'hF, 32'h0,        0, 1, 32'h99AABBCC, 4'd4),  // R4 load beats advance
        mk(4'd0, 3'b010, 1, 1, 0, 1, 1, 4'hF, 32'h0,        0, 1, 32'hDDEEFF00, 4'd2),  // R2 one-cycle latency
        mk(4'd0, 3'b010, 1, 1, 0, 1, 1, 4'hF, 32'h0,        0, 1, 32'h11223344, 4'd6)   // R6 wrap again
    };

    task automatic chk(string tag, logic ev, logic [31:0] ed);
        compared++;
        if (rvalid !== ev || rdata !== ed) begin
            mismatched++;
            $display("FAIL %s: rvalid=%0b rdata=%h expected rvalid=%0b rdata=%h",
                     tag, rvalid, rdata, ev, ed);
        end
    endtask

    task automatic apply(vec_t v);
        addr = v.a; {cs1_n, cs2, cs3_n} = v.ce;
        strb_p_n = v.p; strb_c_n = v.c; adv_n = v.adv;
        gw_n = v.gw; bwe_n = v.bwe; bsel_n = v.bsel; wdata = v.wd; oe_n = v.oe;
    endtask

    initial begin
        repeat (2) @(posedge clk);
        #2 chk("R1 in reset", 1'b0, 32'h0);
        @(negedge clk) rst_n = 1'b1;
        @(posedge clk);
        #2 chk("R1 after reset", 1'b0, 32'h0);

        for (int i = 0; i < NV; i++) begin
            @(negedge clk) apply(VEC[i]);
            @(posedge clk);
            #2 chk($sformatf("R%0d vector %0d", VEC[i].rq, i), VEC[i].ev, VEC[i].ed);
        end

        // R10: output enable acts without a clock edge
        @(negedge clk) apply(mk(4'd0, 3'b010, 1, 1, 1, 1, 1, 4'hF, 32'h0, 0, 1, 32'h0, 4'd10));
        #1 oe_n = 1'b1;
        #1 chk("R10 oe raised mid-cycle", 1'b0, 32'h0);
        oe_n = 1'b0;
        #1 chk("R10 oe lowered mid-cycle", 1'b1, 32'h11223344);

        // R1: asynchronous reset quiets the output
        @(negedge clk) rst_n = 1'b0;
        #1 chk("R1 async reset", 1'b0, 32'h0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        #(200000 * 10);
        if (!done) begin
            mismatched++;
            $display("FAIL watchdog: run did not complete");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end
endmodule